// File: doc/BRIEF.md
# Async memory ready-wait controller

This block runs the data phase of one access to a single external asynchronous memory bank. An internal master raises a request together with a read/write flag. While the block is idle it accepts the request. It then pulls the active-low bank strobes low and counts down a programmable access time, with one count for reads and one for writes. When that count runs out, the access either finishes at once or, if ready handling is on, waits for an external ready line to reach a programmable active level.

The ready line passes through a two-stage synchronizer, and the block samples it only once the access count is used up. An optional 64-clock timeout starts at the same moment. If ready has not been seen when the timeout runs out, the access ends with an error. Completion is reported by a one-clock acknowledge pulse, and an error flag goes high with that pulse only on a timeout. The chip-select pin can show the bank select by itself, or the bank select merged with one of the three strobes. All configuration inputs are static levels.

Top module: `amem_wait_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_rd_n, mem_oe_n and mem_wr_n are high, and ack and err are low.
- R2: A request is accepted only at a clock edge where the block is idle. The read/write flag is captured at that edge. Changes on req or req_write during an access have no effect until it ends.
- R3: During a read, mem_rd_n and mem_oe_n are low and mem_wr_n is high. During a write, mem_wr_n is low and mem_rd_n and mem_oe_n are high. Each pattern holds from the acceptance edge until completion.
- R4: The access count is taken from cfg_rd_cnt (reads) or cfg_wr_cnt (writes) as N, and a value of 0 counts as N=1. With ready handling off, the strobes stay active for exactly N cycles after the acceptance edge. ack is high in the cycle that follows, and in that cycle every strobe and the chip select are already high.
- R5: When cfg_rdy_en=0, ext_rdy is ignored and no timeout error is ever produced, whatever the value of cfg_abort_en.
- R6: When cfg_rdy_en=1, completion happens at the first clock edge that is at least N+1 edges after the acceptance edge and at which ext_rdy, as it stood two edges earlier, was at its active level.
- R7: cfg_rdy_pol sets the active level of ext_rdy: 0 means active low and 1 means active high.
- R8: This applies when cfg_rdy_en=1 and cfg_abort_en=1. If ready has not completed the access by edge N+64 after acceptance, the access ends at that edge with ack and err both high. If ready is seen at that same edge, the access completes normally.
- R9: With cfg_rdy_en=1 and cfg_abort_en=0, the block waits for ready with no time limit.
- R10: ack is high for exactly one cycle per access. err is high only together with ack, and only on a timeout.
- R11: cfg_sel_mode sets mem_cs_n as follows. 0 gives the bank select alone. 1 gives the bank select ORed with mem_rd_n, 2 the bank select ORed with mem_oe_n, and 3 the bank select ORed with mem_wr_n. The bank select is active-low during the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read, captured with req |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout error, valid with ack |
| cfg_rdy_en | input | 1 | Enable ready wait |
| cfg_rdy_pol | input | 1 | Ready active level (1 = high) |
| cfg_abort_en | input | 1 | Enable 64-clock ready timeout |
| cfg_sel_mode | input | 2 | Chip-select merge mode |
| cfg_rd_cnt | input | 6 | Read access count |
| cfg_wr_cnt | input | 6 | Write access count |
| ext_rdy | input | 1 | Asynchronous ready from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong phase or a miscounted down-counter shows up at the ports in the exact cycle the ack pulse lands, because the bench knows that cycle for every access. The bench checks the strobe pattern in every cycle of the access, so a corrupted read/write flag or merge mode shows on the first cycle after acceptance. A timeout counter that is off by one, or a ready/timeout priority that is swapped, changes the ack cycle or the err level exactly at the N+64 boundary, and the bench tests that boundary on both sides.

// File: rtl/amem_wait_pkg.sv
`timescale 1ns/1ps
package amem_wait_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_WAIT   = 2'd2
    } amw_state_e;

    typedef struct packed {
        amw_state_e st;
        logic       is_wr;
        logic       ack;
        logic       err;
    } amw_ctl_s;

    typedef enum logic [1:0] {
        SEL_BANK  = 2'd0,
        SEL_OR_RD = 2'd1,
        SEL_OR_OE = 2'd2,
        SEL_OR_WR = 2'd3
    } amw_sel_e;

endpackage

// File: rtl/amem_rdy_sync.sv
`timescale 1ns/1ps
module amem_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            assign sh_d = din;
        end else begin : g_chain
            assign sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/amem_down_cnt.sv
`timescale 1ns/1ps
module amem_down_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)      cnt_d = load_val;
        else if (dec)  cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == ONE);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

    // R8
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/amem_sel_mux.sv
`timescale 1ns/1ps
module amem_sel_mux
    import amem_wait_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  amw_sel_e mode,
    input  logic     bank_n,
    input  logic     rd_n,
    input  logic     oe_n,
    input  logic     wr_n,
    output logic     cs_n
);
    always_comb begin
        unique case (mode)
            SEL_BANK:  cs_n = bank_n;
            SEL_OR_RD: cs_n = bank_n | rd_n;
            SEL_OR_OE: cs_n = bank_n | oe_n;
            SEL_OR_WR: cs_n = bank_n | wr_n;
            default:   cs_n = 1'b1;
        endcase
    end

    // R11
    cs_needs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !bank_n);
endmodule

// File: rtl/amem_wait_ctrl.sv
`timescale 1ns/1ps
module amem_wait_ctrl
    import amem_wait_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int ABORT_CYC   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    output logic             ack,
    output logic             err,
    input  logic             cfg_rdy_en,
    input  logic             cfg_rdy_pol,
    input  logic             cfg_abort_en,
    input  logic [1:0]       cfg_sel_mode,
    input  logic [CNT_W-1:0] cfg_rd_cnt,
    input  logic [CNT_W-1:0] cfg_wr_cnt,
    input  logic             ext_rdy,
    output logic             mem_cs_n,
    output logic             mem_rd_n,
    output logic             mem_oe_n,
    output logic             mem_wr_n
);
    localparam int ABT_W = $clog2(ABORT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MIN   = CNT_W'(1);
    localparam logic [ABT_W-1:0] ABT_START = ABT_W'(ABORT_CYC);

    amw_ctl_s ctl_d;
    amw_ctl_s ctl_q;

    logic             rdy_s;
    logic             rdy_act;
    logic             acc_load;
    logic             acc_dec;
    logic             acc_last;
    logic             abt_load;
    logic             abt_dec;
    logic             abt_last;
    logic [CNT_W-1:0] eff_rd;
    logic [CNT_W-1:0] eff_wr;
    logic [CNT_W-1:0] acc_val;
    logic             active;
    logic             bank_n;

    amem_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_rdy),
        .dout (rdy_s)
    );

    assign rdy_act = (rdy_s == cfg_rdy_pol);

    // a zero count still gives one strobe cycle
    assign eff_rd  = (cfg_rd_cnt == '0) ? CNT_MIN : cfg_rd_cnt;
    assign eff_wr  = (cfg_wr_cnt == '0) ? CNT_MIN : cfg_wr_cnt;
    assign acc_val = req_write ? eff_wr : eff_rd;

    amem_down_cnt #(.W(CNT_W)) u_acc_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (acc_load),
        .load_val(acc_val),
        .dec     (acc_dec),
        .last    (acc_last)
    );

    amem_down_cnt #(.W(ABT_W)) u_abt_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (abt_load),
        .load_val(ABT_START),
        .dec     (abt_dec),
        .last    (abt_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        ctl_d.err = 1'b0;
        acc_load  = 1'b0;
        acc_dec   = 1'b0;
        abt_load  = 1'b0;
        abt_dec   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.st    = ST_ACCESS;
                    ctl_d.is_wr = req_write;
                    acc_load    = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (acc_last) begin
                    if (cfg_rdy_en) begin
                        ctl_d.st = ST_WAIT;
                        abt_load = 1'b1;
                    end else begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.ack = 1'b1;
                    end
                end else begin
                    acc_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rdy_act) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.ack = 1'b1;
                end else if (cfg_abort_en && abt_last) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.ack = 1'b1;
                    ctl_d.err = 1'b1;
                end else begin
                    abt_dec = !abt_last;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.is_wr <= 1'b0;
            ctl_q.ack   <= 1'b0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active   = (ctl_q.st != ST_IDLE);
    assign bank_n   = !active;
    assign mem_rd_n = !(active && !ctl_q.is_wr);
    assign mem_oe_n = !(active && !ctl_q.is_wr);
    assign mem_wr_n = !(active && ctl_q.is_wr);
    assign ack      = ctl_q.ack;
    assign err      = ctl_q.err;

    amem_sel_mux u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (amw_sel_e'(cfg_sel_mode)),
        .bank_n(bank_n),
        .rd_n  (mem_rd_n),
        .oe_n  (mem_oe_n),
        .wr_n  (mem_wr_n),
        .cs_n  (mem_cs_n)
    );

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R10
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);

    // R4
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (mem_rd_n && mem_oe_n && mem_wr_n && mem_cs_n));

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R5
    no_abort_wo_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cfg_rdy_en && cfg_abort_en));

    // R8
    abort_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && abt_last && !rdy_act && cfg_abort_en) |=> (ack && err));

    // R2
    capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE) |=> (ctl_q.st == ST_IDLE || $stable(ctl_q.is_wr)));
endmodule

// File: tb/amem_wait_ctrl_tb.sv
`timescale 1ns/1ps
module amem_wait_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req, req_write;
    logic       ack, err;
    logic       cfg_rdy_en, cfg_rdy_pol, cfg_abort_en;
    logic [1:0] cfg_sel_mode;
    logic [5:0] cfg_rd_cnt, cfg_wr_cnt;
    logic       ext_rdy;
    logic       mem_cs_n, mem_rd_n, mem_oe_n, mem_wr_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    amem_wait_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .ack(ack), .err(err), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_pol(cfg_rdy_pol),
        .cfg_abort_en(cfg_abort_en), .cfg_sel_mode(cfg_sel_mode),
        .cfg_rd_cnt(cfg_rd_cnt), .cfg_wr_cnt(cfg_wr_cnt), .ext_rdy(ext_rdy),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_oe_n(mem_oe_n), .mem_wr_n(mem_wr_n)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // completion edge index after acceptance, and expected err
    function automatic int exp_cycle(input int n_eff, input bit ren, input bit aen, input int k, output bit e);
        int c;
        e = 1'b0;
        if (!ren) return n_eff;
        c = (n_eff + 1 > k + 2) ? n_eff + 1 : k + 2;
        if (aen && c > n_eff + 64) begin
            e = 1'b1;
            c = n_eff + 64;
        end
        return c;
    endfunction

    function automatic bit exp_cs(input int mode, input bit wr);
        if (mode == 1 || mode == 2) return wr;
        if (mode == 3) return !wr;
        return 1'b0;
    endfunction

    task automatic run_access(input bit wr, input int cnt, input int mode, input bit ren,
                              input bit pol, input bit aen, input int k, input bit hold,
                              input string tag);
        int  n_eff, cyc, bad, expc;
        bit  expe, errv, done, rel;
        cfg_rd_cnt   = 6'(cnt);
        cfg_wr_cnt   = 6'(cnt);
        cfg_sel_mode = 2'(mode);
        cfg_rdy_en   = ren;
        cfg_rdy_pol  = pol;
        cfg_abort_en = aen;
        ext_rdy      = !pol;
        repeat (3) @(negedge clk);
        req       = 1'b1;
        req_write = wr;
        @(negedge clk);
        n_eff = (cnt == 0) ? 1 : cnt;
        expc  = exp_cycle(n_eff, ren, aen, k, expe);
        bad   = 0;
        if (mem_rd_n !== wr || mem_oe_n !== wr || mem_wr_n !== !wr || mem_cs_n !== exp_cs(mode, wr)) bad++;
        if (!hold) req = 1'b0;
        req_write = !wr;
        done = 1'b0; cyc = 0; errv = 1'b0; rel = 1'b0;
        for (int j = 1; j <= 400 && !done; j++) begin
            if (j == k) ext_rdy = pol;
            @(negedge clk);
            if (ack) begin
                done = 1'b1;
                cyc  = j;
                errv = err;
                rel  = mem_rd_n && mem_oe_n && mem_wr_n && mem_cs_n;
            end else if (mem_rd_n !== wr || mem_oe_n !== wr || mem_wr_n !== !wr ||
                         mem_cs_n !== exp_cs(mode, wr)) begin
                bad++;
            end
        end
        req     = 1'b0;
        ext_rdy = !pol;
        chk(bad == 0, "R3,R11", "strobe pattern mismatches", bad, 0);
        chk(cyc == expc, tag, "ack cycle", cyc, expc);
        chk(errv == expe, tag, "err at ack", int'(errv), int'(expe));
        chk(rel, "R4", "strobes released in ack cycle", int'(rel), 1);
        @(negedge clk);
        chk(!ack && !err, "R10", "ack/err after pulse", int'({ack, err}), 0);
        chk(mem_cs_n && mem_rd_n && mem_oe_n && mem_wr_n, "R2", "idle after access",
            int'({mem_cs_n, mem_rd_n, mem_oe_n, mem_wr_n}), 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not end actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        rst_n = 1'b0; req = 1'b0; req_write = 1'b0;
        cfg_rdy_en = 1'b0; cfg_rdy_pol = 1'b1; cfg_abort_en = 1'b0;
        cfg_sel_mode = 2'd0; cfg_rd_cnt = 6'd1; cfg_wr_cnt = 6'd1; ext_rdy = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_cs_n && mem_rd_n && mem_oe_n && mem_wr_n, "R1", "strobes after reset",
            int'({mem_cs_n, mem_rd_n, mem_oe_n, mem_wr_n}), 15);
        chk(!ack && !err, "R1", "ack/err after reset", int'({ack, err}), 0);

        // R5: ready ignored, abort enable irrelevant
        run_access(1'b0, 5, 0, 1'b0, 1'b1, 1'b1, 1, 1'b0, "R5");
        // R4: zero count and maximum count
        run_access(1'b1, 0, 0, 1'b0, 1'b1, 1'b0, 1000, 1'b0, "R4");
        run_access(1'b0, 63, 1, 1'b0, 1'b0, 1'b0, 1000, 1'b0, "R4");
        // R6: ready already present
        run_access(1'b0, 3, 2, 1'b1, 1'b1, 1'b1, 1, 1'b0, "R6");
        // R7: active-low ready arriving late
        run_access(1'b1, 3, 3, 1'b1, 1'b0, 1'b1, 20, 1'b0, "R7");
        // R8: timeout, ready never active
        run_access(1'b0, 4, 0, 1'b1, 1'b1, 1'b1, 1000, 1'b0, "R8");
        // R8: ready on the final timeout edge wins
        run_access(1'b1, 4, 0, 1'b1, 1'b0, 1'b1, 66, 1'b0, "R8");
        // R8: ready one edge too late
        run_access(1'b0, 4, 0, 1'b1, 1'b1, 1'b1, 67, 1'b0, "R8");
        // R9: no timeout, long wait
        run_access(1'b1, 4, 1, 1'b1, 1'b1, 1'b0, 154, 1'b0, "R9");
        // R2: req held and req_write flipped during the access
        run_access(1'b0, 6, 3, 1'b0, 1'b1, 1'b0, 1000, 1'b1, "R2");
        run_access(1'b1, 2, 1, 1'b1, 1'b1, 1'b0, 8, 1'b1, "R2");
        // R11: every merge mode for both directions
        for (int m = 0; m < 4; m++) begin
            run_access(1'b0, 2, m, 1'b0, 1'b1, 1'b0, 1000, 1'b0, "R11");
            run_access(1'b1, 2, m, 1'b0, 1'b1, 1'b0, 1000, 1'b0, "R11");
        end

        // random mix, R6 timing rule
        for (int i = 0; i < 40; i++) begin
            bit r_wr, r_ren, r_pol, r_aen;
            int r_cnt, r_mode, r_k;
            r_wr   = 1'($urandom);
            r_ren  = 1'($urandom);
            r_pol  = 1'($urandom);
            r_aen  = 1'($urandom);
            r_mode = int'($urandom % 4);
            r_cnt  = int'($urandom % 64);
            r_k    = 1 + int'($urandom % ((r_cnt == 0 ? 1 : r_cnt) + 80));
            if (!r_aen && r_k > (r_cnt == 0 ? 1 : r_cnt) + 60) r_k = (r_cnt == 0 ? 1 : r_cnt) + 60;
            run_access(r_wr, r_cnt, r_mode, r_ren, r_pol, r_aen, r_k, 1'b0, "R6");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule